// File: doc/BRIEF.md
# Multicart PRG Window Mapper

This block does the program-memory bank switching for a cartridge that holds several games. It watches the CPU's write cycles in the upper 40 KB of the address space, from $6000 to $FFFF. It keeps two registers: a 4-bit outer bank that picks one game, and a 2-bit layout mode. Every CPU address from $6000 up falls in one of five 8 KB windows. The block combines the outer bank with a fixed offset chosen by the mode and the window, which gives a 6-bit 8 KB ROM bank number. That number, joined to the low 13 address bits, drives the program ROM. The block also tells the video side whether the nametables are mirrored horizontally or vertically.

Writes from $6000 to $7FFF load both mode bits. Writes from $8000 to $FFFF load the outer bank. Writes from $C000 to $DFFF also load the upper mode bit. The mapping outputs are combinational from the two registers, so a read in the cycle after a write already sees the new layout. Character memory is a single fixed 8 KB RAM bank and needs no logic here.

Top module: `multicart_prg_map`

## Requirements
- R1: A synchronous active-high `rst` sets the outer bank to 0 and the mode to 1. Reset takes priority over a write presented in the same cycle.
- R2: A write with `cpu_addr` in $6000-$7FFF sets mode bit 1 to `cpu_data[4]` and mode bit 0 to `cpu_data[1]`. It leaves the outer bank unchanged.
- R3: A write with `cpu_addr` in $8000-$FFFF loads the outer bank from `cpu_data[3:0]`. The outer bank forms bits 5:2 of every bank number.
- R4: A write with `cpu_addr` in $C000-$DFFF also sets mode bit 1 to `cpu_data[4]` and keeps mode bit 0. A write to $8000-$BFFF or $E000-$FFFF leaves the mode unchanged.
- R5: In modes 1 and 3 the bank number is outer|0x23 for $6000-$7FFF. It is outer|0, outer|1, outer|2 and outer|3 for the windows at $8000, $A000, $C000 and $E000.
- R6: In mode 0 the bank number is outer|0x2F for $6000-$7FFF. It is outer|0 for $8000, outer|1 for $A000, outer|0x0E for $C000 and outer|0x0F for $E000.
- R7: In mode 2 the bank number is outer|0x2F for $6000-$7FFF. It is outer|2 for $8000, outer|3 for $A000, outer|0x0E for $C000 and outer|0x0F for $E000.
- R8: `mirror_horiz` is 1 (horizontal) in mode 3 and 0 (vertical) in modes 0, 1 and 2.
- R9: `prg_ce` is 1 only for `cpu_addr` at $6000 or above. Below $6000, `prg_ce`, `prg_bank` and `prg_addr` are 0, and writes have no effect on the mapping.
- R10: When `prg_ce` is 1, `prg_addr` equals `{prg_bank, cpu_addr[12:0]}`.
- R11: The registers change only on a clock edge with `cpu_wr` high. The outputs in the following cycle reflect the new values. Without a write, the mapping holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| prg_ce | output | 1 | Program ROM enable, address at $6000 or above |
| prg_bank | output | 6 | Selected 8 KB program bank |
| prg_addr | output | 19 | Program ROM byte address |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
Two updates can meet in a single edge. A write in $C000-$DFFF changes the outer bank and the upper mode bit together. A reset can also coincide with a write that would otherwise change the mode. The bench provokes the first with data that changes both fields at once. It then reads windows whose expected bank depends on both fields, so a half-applied update gives a wrong number. The bench provokes the second by holding `rst` and `cpu_wr` high in the same cycle. It judges that case by the $6000 window reading outer|0x23 with vertical mirroring, the state reset must leave.

// File: rtl/multicart_prg_map.sv
module multicart_prg_map #(
  parameter int OUTER_W = 4,
  parameter int OFS_W   = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [15:0]                cpu_addr,
  input  logic [7:0]                 cpu_data,
  input  logic                       cpu_wr,
  output logic                       prg_ce,
  output logic [OUTER_W+1:0]         prg_bank,
  output logic [OUTER_W+OFS_W+1:0]   prg_addr,
  output logic                       mirror_horiz
);

  localparam int BANK_W = OUTER_W + 2;

  logic [OUTER_W-1:0] outer_q;
  logic [1:0]         mode_q;
  logic [BANK_W-1:0]  offs;

  wire [2:0] win     = cpu_addr[15:13];
  wire       wr_low  = cpu_wr && (win == 3'd3);
  wire       wr_high = cpu_wr && cpu_addr[15];
  wire       wr_cx   = cpu_wr && (win == 3'd6);
  wire       unused_data = ^cpu_data[7:5];

  always_ff @(posedge clk) begin
    if (rst) begin
      outer_q <= '0;
      mode_q  <= 2'b01;
    end else begin
      if (wr_low)  mode_q    <= {cpu_data[4], cpu_data[1]};
      if (wr_high) outer_q   <= cpu_data[OUTER_W-1:0];
      if (wr_cx)   mode_q[1] <= cpu_data[4];
    end
  end

  always_comb begin
    offs = '0;
    if (win == 3'd3) begin
      offs = mode_q[0] ? BANK_W'(6'h23) : BANK_W'(6'h2F);
    end else if (cpu_addr[15]) begin
      if (mode_q[0])
        offs = BANK_W'({cpu_addr[14], cpu_addr[13]});
      else if (cpu_addr[14])
        offs = BANK_W'({3'b111, cpu_addr[13]});
      else
        offs = BANK_W'({mode_q[1], cpu_addr[13]});
    end
  end

  assign prg_ce       = (win >= 3'd3);
  assign prg_bank     = prg_ce ? ({outer_q, 2'b00} | offs) : '0;
  assign prg_addr     = prg_ce ? {prg_bank, cpu_addr[OFS_W-1:0]} : '0;
  assign mirror_horiz = (mode_q == 2'b11);

  p_reset_vals_r1: assert property (@(posedge clk)
    rst |=> (outer_q == '0 && mode_q == 2'b01));

  p_low_write_mode_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && win == 3'd3) |=> (mode_q == {$past(cpu_data[4]), $past(cpu_data[1])}
                                 && $stable(outer_q)));

  p_high_write_outer_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15]) |=> (outer_q == $past(cpu_data[OUTER_W-1:0])));

  p_keep_mode_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15]) |=> (mode_q[0] == $past(mode_q[0])));

  p_outer_on_top_r5: assert property (@(posedge clk) disable iff (rst)
    (prg_ce && cpu_addr[15] && mode_q[0]) |-> (prg_bank[BANK_W-1:2] == outer_q));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr |=> ($stable(outer_q) && $stable(mode_q)));

  p_no_ce_low_r9: assert property (@(posedge clk) disable iff (rst)
    !prg_ce |-> (prg_addr == '0 && prg_bank == '0));

endmodule

// File: tb/sim_multicart_prg_map.sv
module sim_multicart_prg_map;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic        prg_ce;
  logic [5:0]  prg_bank;
  logic [18:0] prg_addr;
  logic        mirror_horiz;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  multicart_prg_map u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .prg_ce(prg_ce), .prg_bank(prg_bank),
    .prg_addr(prg_addr), .mirror_horiz(mirror_horiz)
  );

  // {wr, addr, data, exp_bank, exp_mirror, exp_ce}
  localparam int NV = 51;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h6000, 8'h00, 6'h23, 1'b0, 1'b1}, // R1 R5 reset layout
    {1'b0, 16'h8000, 8'h00, 6'h00, 1'b0, 1'b1}, // R5
    {1'b0, 16'h9FFF, 8'h00, 6'h00, 1'b0, 1'b1}, // R5
    {1'b0, 16'hA000, 8'h00, 6'h01, 1'b0, 1'b1}, // R5
    {1'b0, 16'hC000, 8'h00, 6'h02, 1'b0, 1'b1}, // R5
    {1'b0, 16'hDFFF, 8'h00, 6'h02, 1'b0, 1'b1}, // R5
    {1'b0, 16'hE000, 8'h00, 6'h03, 1'b0, 1'b1}, // R5
    {1'b0, 16'hFFFF, 8'h00, 6'h03, 1'b0, 1'b1}, // R5
    {1'b0, 16'h7FFF, 8'h00, 6'h23, 1'b0, 1'b1}, // R5
    {1'b0, 16'h5FFF, 8'h00, 6'h00, 1'b0, 1'b0}, // R9
    {1'b1, 16'h8000, 8'h05, 6'h00, 1'b0, 1'b0}, // R3 outer=5
    {1'b0, 16'h8000, 8'h00, 6'h14, 1'b0, 1'b1}, // R3 R11
    {1'b0, 16'hE000, 8'h00, 6'h17, 1'b0, 1'b1}, // R3
    {1'b0, 16'h6000, 8'h00, 6'h37, 1'b0, 1'b1}, // R3 R5
    {1'b1, 16'h6000, 8'h00, 6'h00, 1'b0, 1'b0}, // R2 mode 0
    {1'b0, 16'h6000, 8'h00, 6'h3F, 1'b0, 1'b1}, // R6
    {1'b0, 16'h8000, 8'h00, 6'h14, 1'b0, 1'b1}, // R6
    {1'b0, 16'hA000, 8'h00, 6'h15, 1'b0, 1'b1}, // R6
    {1'b0, 16'hC000, 8'h00, 6'h1E, 1'b0, 1'b1}, // R6
    {1'b0, 16'hE000, 8'h00, 6'h1F, 1'b0, 1'b1}, // R6
    {1'b1, 16'h7FFF, 8'h10, 6'h00, 1'b0, 1'b0}, // R2 mode 2
    {1'b0, 16'h8000, 8'h00, 6'h16, 1'b0, 1'b1}, // R7
    {1'b0, 16'hBFFF, 8'h00, 6'h17, 1'b0, 1'b1}, // R7
    {1'b0, 16'hC000, 8'h00, 6'h1E, 1'b0, 1'b1}, // R7
    {1'b0, 16'hFFFF, 8'h00, 6'h1F, 1'b0, 1'b1}, // R7
    {1'b0, 16'h6000, 8'h00, 6'h3F, 1'b0, 1'b1}, // R7
    {1'b1, 16'h6123, 8'h12, 6'h00, 1'b0, 1'b0}, // R2 mode 3
    {1'b0, 16'h8000, 8'h00, 6'h14, 1'b1, 1'b1}, // R5 R8
    {1'b0, 16'h6000, 8'h00, 6'h37, 1'b1, 1'b1}, // R5 R8
    {1'b0, 16'hFFFF, 8'h00, 6'h17, 1'b1, 1'b1}, // R5 R8
    {1'b1, 16'hC000, 8'h0A, 6'h00, 1'b0, 1'b0}, // R4 outer=A, mode 1
    {1'b0, 16'h8000, 8'h00, 6'h28, 1'b0, 1'b1}, // R4 R8
    {1'b0, 16'h6000, 8'h00, 6'h2B, 1'b0, 1'b1}, // R4
    {1'b1, 16'hE000, 8'h1F, 6'h00, 1'b0, 1'b0}, // R4 outer=F, mode kept
    {1'b0, 16'hA000, 8'h00, 6'h3D, 1'b0, 1'b1}, // R4
    {1'b0, 16'h6000, 8'h00, 6'h3F, 1'b0, 1'b1}, // R4
    {1'b1, 16'hD000, 8'h13, 6'h00, 1'b0, 1'b0}, // R4 outer=3, mode 3
    {1'b0, 16'hC000, 8'h00, 6'h0E, 1'b1, 1'b1}, // R4 R8
    {1'b1, 16'h4000, 8'h00, 6'h00, 1'b0, 1'b0}, // R9 ignored write
    {1'b0, 16'h8000, 8'h00, 6'h0C, 1'b1, 1'b1}, // R9
    {1'b0, 16'h0000, 8'h00, 6'h00, 1'b1, 1'b0}, // R9
    {1'b1, 16'h8000, 8'h10, 6'h00, 1'b0, 1'b0}, // R4 outer=0, mode kept
    {1'b0, 16'h8000, 8'h00, 6'h00, 1'b1, 1'b1}, // R4
    {1'b1, 16'hBFFF, 8'h13, 6'h00, 1'b0, 1'b0}, // R4 outer=3, mode kept
    {1'b0, 16'hE000, 8'h00, 6'h0F, 1'b1, 1'b1}, // R4 R8
    {1'b1, 16'h6000, 8'h02, 6'h00, 1'b0, 1'b0}, // R2 mode 1
    {1'b0, 16'h6000, 8'h00, 6'h2F, 1'b0, 1'b1}, // R2
    {1'b1, 16'h6000, 8'h00, 6'h00, 1'b0, 1'b0}, // R2 mode 0
    {1'b1, 16'hA000, 8'h01, 6'h00, 1'b0, 1'b0}, // R3 outer=1
    {1'b0, 16'h6000, 8'h00, 6'h2F, 1'b0, 1'b1}, // R6
    {1'b0, 16'hA000, 8'h00, 6'h05, 1'b0, 1'b1}  // R6 R10
  };

  task automatic check(input string tag, input logic [5:0] eb, input logic em, input logic ec);
    logic [18:0] ea;
    ea = ec ? {eb, cpu_addr[12:0]} : 19'd0;
    n_vec++;
    if (prg_bank !== eb || mirror_horiz !== em || prg_ce !== ec || prg_addr !== ea) begin
      n_bad++;
      $display("FAIL %s addr=%h: bank=%h mir=%b ce=%b paddr=%h, expected bank=%h mir=%b ce=%b paddr=%h (R10)",
               tag, cpu_addr, prg_bank, mirror_horiz, prg_ce, prg_addr, eb, em, ec, ea);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input string tag,
                    input logic [5:0] eb, input logic em, input logic ec);
    @(negedge clk);
    cpu_addr = a;
    #1 check(tag, eb, em, ec);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(16'h6000, "R1", 6'h23, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) wr(VEC[i][31:16], VEC[i][15:8]);
      else rd(VEC[i][31:16], "R5/R6/R7/R9 table", VEC[i][7:2], VEC[i][1], VEC[i][0]);
    end

    // R11: idle cycles with toggling address keep mapping (mode 0, outer 1)
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cpu_addr = 16'h6000 + 16'(k * 16'h1357);
      cpu_data = 8'hFF;
    end
    rd(16'hC000, "R11 hold", 6'h0E, 1'b0, 1'b1);

    // R11: new mapping is visible exactly one edge after the write
    @(negedge clk);
    cpu_addr = 16'hD000; cpu_data = 8'h16; cpu_wr = 1'b1;
    #1 check("R11 before edge", 6'h0E, 1'b0, 1'b1);
    @(negedge clk);
    cpu_wr = 1'b0;
    #1 check("R4 R11 after edge", 6'h1E, 1'b0, 1'b1);
    rd(16'h8000, "R7 both fields", 6'h1A, 1'b0, 1'b1);

    // R1: reset and write in the same cycle, reset wins
    @(negedge clk);
    rst = 1'b1; cpu_addr = 16'h6000; cpu_data = 8'h12; cpu_wr = 1'b1;
    @(negedge clk);
    rst = 1'b0; cpu_wr = 1'b0;
    #1 check("R1 reset over write", 6'h23, 1'b0, 1'b1);
    rd(16'hE000, "R1", 6'h03, 1'b0, 1'b1);

    // R9: write at $5FFF does not touch mode or outer
    wr(16'h5FFF, 8'h1F);
    rd(16'h6000, "R9 low write", 6'h23, 1'b0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule